// File: doc/BRIEF.md
# Dual-Edge Strobed Burst Link

This block moves bursts of 64-bit words over a wide parallel bus between a sending end and a receiving end that share one system clock. Each transfer starts with an interlocked address exchange: the sender drives a start address and a burst length onto the data lines and lowers a request line. It then waits until the receiver has answered on an acknowledge line and released it again. After that the sender streams the words with no per-word acknowledgment. Every transition of a single strobe line qualifies one word.

The first word of a burst always rides a falling strobe edge. Words then alternate between falling edges (odd words) and rising edges (even words). The receiver passes the strobe through a two-flop synchronizer, finds transitions by comparing consecutive synchronized values, and captures the data that went through the same synchronizer. A termination line closes the burst. While it is low, the sender returns the strobe to its idle-high level, and the receiver gives a one-cycle verdict: done when the number of captured words matches the advertised length, error when it does not.

The sending end and the receiving end come out as separate port groups, so the bus between them is wired outside the block and can be observed there.

Top module: `dsb_link`

## Requirements
- R1: The sender changes no strobe level and requests no word until the address exchange has completed. The address exchange is the request line low, then the acknowledge line low, then the request released, then the acknowledge released.
- R2: The request line (active low) stays low until the acknowledge is seen low. The data phase starts only after the acknowledge is seen high again. During the request the data lines carry the inverted header: address in bits 47..0 and length minus one in bits 55..48. The receiver presents both on its header outputs.
- R3: A burst of length N, where N is 1 to 256 and is given as N−1, produces exactly N strobe transitions before the termination line goes low.
- R4: The strobe idles high, so word 1 is a falling edge, and words alternate from there. The receiver tags a word odd (tag 1) when it arrived on a falling edge.
- R5: The data lines carry the inverted word. That value is in place one clock before its strobe transition and has not changed at the clock after it.
- R6: The sender never waits between words: consecutive strobe transitions are exactly two clocks apart, and a word request occurs every second clock.
- R7: The receiver outputs every captured word exactly once, in burst order, with the value sent.
- R8: After an odd-length burst the strobe is driven back high while termination is low, and the receiver does not count that edge as a word. The strobe is high once the link is idle.
- R9: At termination the receiver pulses done for one cycle if the captured count equals N, and otherwise pulses error for one cycle, never both.
- R10: In reset, request, strobe, termination and acknowledge are high, the data lines are all ones, and busy, word request, word valid, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock shared by both ends |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_start | input | 1 | Begin a transfer (taken when idle) |
| tx_addr | input | 48 | Start address of the burst |
| tx_len_m1 | input | 8 | Burst length minus one |
| tx_beat_data | input | 64 | Word supplied in a cycle where tx_beat_req is high |
| tx_beat_req | output | 1 | Sender takes tx_beat_data at the end of this cycle |
| tx_busy | output | 1 | Sender is in a transfer |
| txo_as_n | output | 1 | Address request, active low |
| txo_stb_n | output | 1 | Data strobe, both edges significant |
| txo_term_n | output | 1 | Termination, active low |
| txo_data_n | output | 64 | Inverted data / header lines |
| txi_ack_n | input | 1 | Address acknowledge seen by the sender |
| rxi_as_n | input | 1 | Address request seen by the receiver |
| rxi_stb_n | input | 1 | Strobe seen by the receiver |
| rxi_term_n | input | 1 | Termination seen by the receiver |
| rxi_data_n | input | 64 | Data lines seen by the receiver |
| rxo_ack_n | output | 1 | Address acknowledge from the receiver |
| rx_addr | output | 48 | Latched start address |
| rx_len_m1 | output | 8 | Latched burst length minus one |
| rx_hdr_valid | output | 1 | One-cycle pulse when a header is latched |
| rx_beat_valid | output | 1 | One-cycle pulse per captured word |
| rx_beat_data | output | 64 | Captured word |
| rx_beat_odd | output | 1 | 1 when the word came on a falling edge |
| rx_done | output | 1 | Count matched at termination (pulse) |
| rx_err | output | 1 | Count mismatched at termination (pulse) |

## Verification
The bench targets these corner cases:
- Length 1. Here the only transition is falling and termination must restore it. A design that counts the restore edge reports two words and flags an error.
- Length 256. This tests that the length counter's top value neither wraps to zero nor stops one word short.
- A held-back acknowledge. A sender that skips the interlock shows strobe activity or word requests while the acknowledge is withheld.
- A final edge removed on the receiver's side. The receiver must then report an error and not done.

Random lengths also test the setup and hold of each word against its edge. Data changed on the same clock as the strobe shows up as wrong captured words.

// File: rtl/dsb_pkg.sv
// Shared state encodings for the dual-edge strobed burst link.
package dsb_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_ADDR_REQ,
        TX_ADDR_REL,
        TX_LOAD,
        TX_TOGGLE,
        TX_TERM_MARK,
        TX_TERM_RESTORE,
        TX_TERM_HOLD
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_ADDR,
        RX_DATA,
        RX_END
    } rx_state_t;

endpackage

// File: rtl/dsb_sync2.sv
// Two-flop synchronizer for a vector of idle-high bus lines.
// Assumes: each bit is sampled independently; the caller keeps related
// bits stable long enough that equal delay keeps them aligned.
module dsb_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two register stages, reset to the idle-high bus level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;
endmodule

// File: rtl/dsb_tx.sv
// Sending end: interlocked header exchange, then one word per strobe
// transition (two clocks per word), then termination that restores the
// strobe high. Assumes the receiver acknowledges the header and that
// beat_data is valid in any cycle where beat_req is high.
module dsb_tx
    import dsb_pkg::*;
#(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 48,
    parameter int LEN_W     = 8,
    parameter int TERM_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  start_len_m1,
    input  logic [DATA_W-1:0] beat_data,
    output logic              beat_req,
    output logic              busy,
    output logic              bus_as_n,
    output logic              bus_stb_n,
    output logic              bus_term_n,
    output logic [DATA_W-1:0] bus_data_n,
    input  logic              bus_ack_n
);
    localparam int CNT_W  = LEN_W + 1;
    localparam int HOLD_W = (TERM_HOLD > 1) ? $clog2(TERM_HOLD) : 1;

    tx_state_t         state_q;
    logic              stb_q;
    logic              as_q;
    logic              term_q;
    logic [DATA_W-1:0] data_q;
    logic [CNT_W-1:0]  remain_q;
    logic [CNT_W-1:0]  len_q;
    logic [HOLD_W-1:0] hold_q;
    logic              ack_s;
    logic [DATA_W-1:0] hdr_word;

    dsb_sync2 #(.W(1)) u_ack_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (bus_ack_n),
        .dout (ack_s)
    );

    // Header word: address in the low bits, length minus one above it.
    always_comb begin
        hdr_word = '0;
        hdr_word[ADDR_W-1:0]      = start_addr;
        hdr_word[ADDR_W +: LEN_W] = start_len_m1;
    end

    // Phase sequencer driving all bus lines from registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= TX_IDLE;
            stb_q    <= 1'b1;
            as_q     <= 1'b1;
            term_q   <= 1'b1;
            data_q   <= '1;
            remain_q <= '0;
            len_q    <= '0;
            hold_q   <= '0;
        end else begin
            case (state_q)
                TX_IDLE: begin
                    if (start) begin
                        as_q     <= 1'b0;
                        data_q   <= ~hdr_word;
                        remain_q <= CNT_W'(start_len_m1) + CNT_W'(1);
                        len_q    <= CNT_W'(start_len_m1) + CNT_W'(1);
                        state_q  <= TX_ADDR_REQ;
                    end
                end
                TX_ADDR_REQ: begin
                    if (!ack_s) begin
                        as_q    <= 1'b1;
                        data_q  <= '1;
                        state_q <= TX_ADDR_REL;
                    end
                end
                TX_ADDR_REL: begin
                    if (ack_s) begin
                        state_q <= TX_LOAD;
                    end
                end
                TX_LOAD: begin
                    data_q  <= ~beat_data;
                    state_q <= TX_TOGGLE;
                end
                TX_TOGGLE: begin
                    stb_q    <= ~stb_q;
                    remain_q <= remain_q - CNT_W'(1);
                    state_q  <= (remain_q == CNT_W'(1)) ? TX_TERM_MARK : TX_LOAD;
                end
                TX_TERM_MARK: begin
                    term_q  <= 1'b0;
                    state_q <= TX_TERM_RESTORE;
                end
                TX_TERM_RESTORE: begin
                    stb_q   <= 1'b1;
                    data_q  <= '1;
                    hold_q  <= '0;
                    state_q <= TX_TERM_HOLD;
                end
                default: begin
                    if (hold_q == HOLD_W'(TERM_HOLD - 1)) begin
                        term_q  <= 1'b1;
                        state_q <= TX_IDLE;
                    end else begin
                        hold_q <= hold_q + HOLD_W'(1);
                    end
                end
            endcase
        end
    end

    assign beat_req   = (state_q == TX_LOAD);
    assign busy       = (state_q != TX_IDLE);
    assign bus_as_n   = as_q;
    assign bus_stb_n  = stb_q;
    assign bus_term_n = term_q;
    assign bus_data_n = data_q;

    // Checker: independent count of strobe transitions within a burst.
    logic             chk_prev_stb_q;
    logic [CNT_W:0]   chk_edges_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_prev_stb_q <= 1'b1;
            chk_edges_q    <= '0;
        end else begin
            chk_prev_stb_q <= stb_q;
            if (state_q == TX_IDLE)
                chk_edges_q <= '0;
            else if (stb_q != chk_prev_stb_q && term_q)
                chk_edges_q <= chk_edges_q + 1'b1;
        end
    end

    assert_edge_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_TERM_RESTORE) |-> (chk_edges_q == {1'b0, len_q}));

    assert_request_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_q && ack_s) |=> !as_q);

    assert_quiet_in_header_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_q) |-> (stb_q && term_q && !beat_req));

    assert_data_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_q != $past(stb_q) && term_q) |-> (data_q == $past(data_q)));

    assert_no_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_req && remain_q > CNT_W'(1)) |=> !beat_req ##1 beat_req);
endmodule

// File: rtl/dsb_rx.sv
// Receiving end: synchronizes all bus lines with equal delay, answers the
// header exchange, captures one word per strobe transition, and gives a
// done/error verdict when termination is seen. Termination takes priority
// over a strobe transition seen in the same cycle.
module dsb_rx
    import dsb_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int ADDR_W = 48,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_as_n,
    input  logic              bus_stb_n,
    input  logic              bus_term_n,
    input  logic [DATA_W-1:0] bus_data_n,
    output logic              bus_ack_n,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic [LEN_W-1:0]  hdr_len_m1,
    output logic              hdr_valid,
    output logic              beat_valid,
    output logic [DATA_W-1:0] beat_data,
    output logic              beat_odd,
    output logic              done,
    output logic              err
);
    localparam int CNT_W = LEN_W + 2;
    localparam int SYN_W = DATA_W + 3;

    logic [SYN_W-1:0]  syn_out;
    logic              as_s;
    logic              stb_s;
    logic              term_s;
    logic [DATA_W-1:0] data_s;

    rx_state_t         state_q;
    logic              stb_prev_q;
    logic              ack_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic              hdr_valid_q;
    logic              beat_valid_q;
    logic [DATA_W-1:0] beat_data_q;
    logic              beat_odd_q;
    logic              done_q;
    logic              err_q;
    logic [CNT_W-1:0]  expect_cnt;

    dsb_sync2 #(.W(SYN_W)) u_bus_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_term_n, bus_as_n, bus_stb_n, bus_data_n}),
        .dout (syn_out)
    );

    assign {term_s, as_s, stb_s, data_s} = syn_out;
    assign expect_cnt = CNT_W'(len_q) + CNT_W'(1);

    // Phase tracking, word capture and termination verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= RX_IDLE;
            stb_prev_q   <= 1'b1;
            ack_q        <= 1'b1;
            cnt_q        <= '0;
            addr_q       <= '0;
            len_q        <= '0;
            hdr_valid_q  <= 1'b0;
            beat_valid_q <= 1'b0;
            beat_data_q  <= '0;
            beat_odd_q   <= 1'b0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
        end else begin
            stb_prev_q   <= stb_s;
            hdr_valid_q  <= 1'b0;
            beat_valid_q <= 1'b0;
            done_q       <= 1'b0;
            err_q        <= 1'b0;
            case (state_q)
                RX_IDLE: begin
                    if (!as_s) begin
                        addr_q      <= ~data_s[ADDR_W-1:0];
                        len_q       <= ~data_s[ADDR_W +: LEN_W];
                        hdr_valid_q <= 1'b1;
                        ack_q       <= 1'b0;
                        state_q     <= RX_ADDR;
                    end
                end
                RX_ADDR: begin
                    if (as_s) begin
                        ack_q   <= 1'b1;
                        cnt_q   <= '0;
                        state_q <= RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (!term_s) begin
                        done_q  <= (cnt_q == expect_cnt);
                        err_q   <= (cnt_q != expect_cnt);
                        state_q <= RX_END;
                    end else if (stb_s != stb_prev_q) begin
                        beat_valid_q <= 1'b1;
                        beat_data_q  <= ~data_s;
                        beat_odd_q   <= ~stb_s;
                        if (cnt_q != '1)
                            cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: begin
                    if (term_s)
                        state_q <= RX_IDLE;
                end
            endcase
        end
    end

    assign bus_ack_n  = ack_q;
    assign hdr_addr   = addr_q;
    assign hdr_len_m1 = len_q;
    assign hdr_valid  = hdr_valid_q;
    assign beat_valid = beat_valid_q;
    assign beat_data  = beat_data_q;
    assign beat_odd   = beat_odd_q;
    assign done       = done_q;
    assign err        = err_q;

    assert_one_verdict_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));

    assert_verdict_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q || err_q) |=> !(done_q || err_q));

    assert_no_word_in_term_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RX_END) |-> !beat_valid_q);

    assert_no_word_before_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_q) |-> !beat_valid_q);
endmodule

// File: rtl/dsb_link.sv
// Top of the dual-edge strobed burst link: a sending end and a receiving
// end whose bus pins are brought out separately; the bus is wired outside.
module dsb_link #(
    parameter int DATA_W    = 64,
    parameter int ADDR_W    = 48,
    parameter int LEN_W     = 8,
    parameter int TERM_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_start,
    input  logic [ADDR_W-1:0] tx_addr,
    input  logic [LEN_W-1:0]  tx_len_m1,
    input  logic [DATA_W-1:0] tx_beat_data,
    output logic              tx_beat_req,
    output logic              tx_busy,
    output logic              txo_as_n,
    output logic              txo_stb_n,
    output logic              txo_term_n,
    output logic [DATA_W-1:0] txo_data_n,
    input  logic              txi_ack_n,
    input  logic              rxi_as_n,
    input  logic              rxi_stb_n,
    input  logic              rxi_term_n,
    input  logic [DATA_W-1:0] rxi_data_n,
    output logic              rxo_ack_n,
    output logic [ADDR_W-1:0] rx_addr,
    output logic [LEN_W-1:0]  rx_len_m1,
    output logic              rx_hdr_valid,
    output logic              rx_beat_valid,
    output logic [DATA_W-1:0] rx_beat_data,
    output logic              rx_beat_odd,
    output logic              rx_done,
    output logic              rx_err
);
    dsb_tx #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .TERM_HOLD(TERM_HOLD)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (tx_start),
        .start_addr  (tx_addr),
        .start_len_m1(tx_len_m1),
        .beat_data   (tx_beat_data),
        .beat_req    (tx_beat_req),
        .busy        (tx_busy),
        .bus_as_n    (txo_as_n),
        .bus_stb_n   (txo_stb_n),
        .bus_term_n  (txo_term_n),
        .bus_data_n  (txo_data_n),
        .bus_ack_n   (txi_ack_n)
    );

    dsb_rx #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
    ) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_as_n  (rxi_as_n),
        .bus_stb_n (rxi_stb_n),
        .bus_term_n(rxi_term_n),
        .bus_data_n(rxi_data_n),
        .bus_ack_n (rxo_ack_n),
        .hdr_addr  (rx_addr),
        .hdr_len_m1(rx_len_m1),
        .hdr_valid (rx_hdr_valid),
        .beat_valid(rx_beat_valid),
        .beat_data (rx_beat_data),
        .beat_odd  (rx_beat_odd),
        .done      (rx_done),
        .err       (rx_err)
    );
endmodule

// File: tb/dsb_link_tb_top.sv
module dsb_link_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_start = 1'b0;
    logic [47:0] tx_addr = '0;
    logic [7:0]  tx_len_m1 = '0;
    logic [63:0] tx_beat_data = '0;
    logic        tx_beat_req, tx_busy;
    logic        txo_as_n, txo_stb_n, txo_term_n;
    logic [63:0] txo_data_n;
    logic        txi_ack_n, rxi_stb_n, rxo_ack_n;
    logic [47:0] rx_addr;
    logic [7:0]  rx_len_m1;
    logic        rx_hdr_valid, rx_beat_valid, rx_beat_odd, rx_done, rx_err;
    logic [63:0] rx_beat_data;

    // Bus wiring with two fault hooks: held-back acknowledge, frozen strobe.
    logic ack_block = 1'b0;
    logic drop_arm = 1'b0;
    logic drop_active = 1'b0;
    logic stb_hold = 1'b1;
    assign txi_ack_n = ack_block ? 1'b1 : rxo_ack_n;
    assign rxi_stb_n = drop_active ? stb_hold : txo_stb_n;

    dsb_link dut_i (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_addr(tx_addr),
        .tx_len_m1(tx_len_m1), .tx_beat_data(tx_beat_data),
        .tx_beat_req(tx_beat_req), .tx_busy(tx_busy),
        .txo_as_n(txo_as_n), .txo_stb_n(txo_stb_n), .txo_term_n(txo_term_n),
        .txo_data_n(txo_data_n), .txi_ack_n(txi_ack_n),
        .rxi_as_n(txo_as_n), .rxi_stb_n(rxi_stb_n), .rxi_term_n(txo_term_n),
        .rxi_data_n(txo_data_n), .rxo_ack_n(rxo_ack_n),
        .rx_addr(rx_addr), .rx_len_m1(rx_len_m1), .rx_hdr_valid(rx_hdr_valid),
        .rx_beat_valid(rx_beat_valid), .rx_beat_data(rx_beat_data),
        .rx_beat_odd(rx_beat_odd), .rx_done(rx_done), .rx_err(rx_err)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    logic [31:0] cur_seed = 32'h1;

    function automatic logic [63:0] pattern(input logic [31:0] s, input int i);
        logic [31:0] iu = 32'(i);
        return {s ^ (iu * 32'h9E3779B9), ~s + iu};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: per-transfer observations, reset when the request falls.
    logic        m_prev_stb = 1'b1;
    logic        m_prev_as = 1'b1;
    logic [63:0] m_prev_data = '1;
    int m_edges, m_first_bad, m_gap_bad, m_stable_bad, m_data_bad, m_phase_bad;
    int m_last_edge, m_rx_beats, m_rx_data_bad, m_tag_bad, m_done, m_err;
    int m_block_bad, fed;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!txo_as_n && m_prev_as) begin
                m_edges = 0; m_first_bad = 0; m_gap_bad = 0; m_stable_bad = 0;
                m_data_bad = 0; m_phase_bad = 0; m_last_edge = 0; m_rx_beats = 0;
                m_rx_data_bad = 0; m_tag_bad = 0; m_done = 0; m_err = 0; fed = 0;
            end
            if (txo_stb_n !== m_prev_stb && txo_term_n) begin
                if (m_edges == 0 && txo_stb_n !== 1'b0) m_first_bad++;
                if (m_edges > 0 && cyc - m_last_edge != 2) m_gap_bad++;
                if (txo_data_n !== m_prev_data) m_stable_bad++;
                if (~txo_data_n !== pattern(cur_seed, m_edges)) m_data_bad++;
                if (!txo_as_n || !txi_ack_n) m_phase_bad++;
                m_last_edge = cyc;
                m_edges++;
            end
            if (rx_beat_valid) begin
                if (rx_beat_data !== pattern(cur_seed, m_rx_beats)) m_rx_data_bad++;
                if (rx_beat_odd !== ((m_rx_beats % 2) == 0)) m_tag_bad++;
                m_rx_beats++;
            end
            if (rx_done) m_done++;
            if (rx_err) m_err++;
            if (ack_block && (!txo_stb_n || tx_beat_req)) m_block_bad++;
            if (drop_active && !txo_term_n) drop_active = 1'b0;
            tx_beat_data = pattern(cur_seed, fed);
            if (tx_beat_req) begin
                if (drop_arm && fed == int'(tx_len_m1)) begin
                    stb_hold = txo_stb_n;
                    drop_active = 1'b1;
                end
                fed++;
            end
            m_prev_stb = txo_stb_n;
            m_prev_as = txo_as_n;
            m_prev_data = txo_data_n;
        end
    end

    task automatic xfer(input logic [47:0] addr, input logic [7:0] lm1,
                        input bit drop, input int block);
        int n = int'(lm1) + 1;
        int exp_rx = drop ? n - 1 : n;
        int t = 0;
        @(negedge clk);
        cur_seed = $urandom;
        tx_addr = addr;
        tx_len_m1 = lm1;
        drop_arm = drop;
        ack_block = (block > 0);
        m_block_bad = 0;
        tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        if (block > 0) begin
            repeat (block) @(negedge clk);
            check(m_block_bad == 0, "R1 quiet while ack held", 64'(m_block_bad), 0);
            check(txo_as_n == 1'b0, "R2 request held", 64'(txo_as_n), 0);
            ack_block = 1'b0;
        end
        while (!((m_done + m_err) > 0 && !tx_busy) && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (8) @(negedge clk);
        drop_arm = 1'b0;
        check(m_edges == n, "R3 strobe transitions", 64'(m_edges), 64'(n));
        check(m_first_bad == 0 && m_tag_bad == 0, "R4 edge parity / tag",
              64'(m_first_bad + m_tag_bad), 0);
        check(m_stable_bad == 0 && m_data_bad == 0, "R5 data around edge",
              64'(m_stable_bad + m_data_bad), 0);
        check(m_gap_bad == 0, "R6 edge spacing", 64'(m_gap_bad), 0);
        check(m_phase_bad == 0, "R1 phase order", 64'(m_phase_bad), 0);
        check(m_rx_beats == exp_rx, "R7 R8 captured count", 64'(m_rx_beats), 64'(exp_rx));
        check(m_rx_data_bad == 0, "R7 captured data", 64'(m_rx_data_bad), 0);
        check(rx_addr == addr && rx_len_m1 == lm1, "R2 header",
              {rx_len_m1, 8'h0, rx_addr}, {lm1, 8'h0, addr});
        if (drop)
            check(m_err == 1 && m_done == 0, "R9 error verdict",
                  64'(m_err * 16 + m_done), 64'h10);
        else
            check(m_done == 1 && m_err == 0, "R9 done verdict",
                  64'(m_done * 16 + m_err), 64'h10);
        check(txo_stb_n == 1'b1 && txo_term_n == 1'b1, "R8 idle strobe high",
              {62'h0, txo_stb_n, txo_term_n}, 64'h3);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R10: reset state
        check(txo_as_n && txo_stb_n && txo_term_n && rxo_ack_n, "R10 idle lines",
              {60'h0, txo_as_n, txo_stb_n, txo_term_n, rxo_ack_n}, 64'hF);
        check(txo_data_n == '1, "R10 data lines", txo_data_n, '1);
        check(!tx_busy && !tx_beat_req && !rx_beat_valid && !rx_done && !rx_err,
              "R10 quiet outputs",
              {59'h0, tx_busy, tx_beat_req, rx_beat_valid, rx_done, rx_err}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // Directed corners
        xfer(48'h0000_1000_0000, 8'd0, 1'b0, 0);    // single word, odd
        xfer(48'h0000_2000_0040, 8'd1, 1'b0, 0);    // two words, even
        xfer(48'h0000_3000_0080, 8'd2, 1'b0, 0);    // three words
        xfer(48'hFFFF_FFFF_FFF8, 8'd255, 1'b0, 0);  // 256 words
        xfer(48'h0000_4000_0000, 8'd4, 1'b0, 20);   // acknowledge held back
        xfer(48'h0000_5000_0000, 8'd3, 1'b1, 0);    // last edge lost: error
        xfer(48'h0000_6000_0000, 8'd0, 1'b1, 0);    // only edge lost: error
        xfer(48'h0000_7000_0000, 8'd6, 1'b1, 0);    // odd length, last lost
        // Constrained random lengths and addresses
        for (int k = 0; k < 14; k++) begin
            logic [7:0] l = (($urandom % 5) == 0) ? 8'($urandom_range(128, 255))
                                                  : 8'($urandom_range(0, 40));
            xfer({$urandom, 16'($urandom)}, l, 1'b0, (($urandom % 4) == 0) ? 7 : 0);
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule